// File: doc/BRIEF.md
# Working Register File with Address Pointers

This block is the working register store of a small 8-bit processor core. It holds thirty-two 8-bit registers. Two byte operands and one aligned 16-bit pair can be read combinationally in the same cycle. One write port stores either a single byte or a 16-bit result into an aligned even/odd pair. Because reads are combinational and writes land on the next rising edge, an operand fetch, an external operation and the write-back of its result fit in one clock cycle.

The six highest registers double as three 16-bit address pointers. A pointer port selects one of them and presents an effective address. It can leave the pointer alone, add a small unsigned displacement, post-increment it or pre-decrement it. The last two write the new value back into the pair. An 8-bit extension register can be placed above the third pointer to form a 24-bit address. A separate data-space port treats the registers as memory at addresses below 0x20. The write sources have a fixed priority when two of them hit the same register in one cycle.

Top module: `wreg_file_top`

## Requirements
- R1: After a synchronous active-high reset, every register and the extension register read as zero.
- R2: The two byte read ports return the addressed register combinationally. A byte write (`wr_en`=1, `wr_wide`=0) stores `wr_data[7:0]` at `wr_idx` on the next rising edge. A read in the same cycle still returns the old value.
- R3: A wide write (`wr_wide`=1) stores `wr_data[7:0]` at the even index and `wr_data[15:8]` at the odd index of the pair containing `wr_idx`; an odd `wr_idx` is treated as the even index below it. The 16-bit read port returns {register idx|1, register idx&~1} for `rd_w_idx`, with the same alignment.
- R4: Mode 1 (post-increment) presents the current pointer value on `ptr_addr[15:0]` and writes back pointer+1, carrying across the pair and wrapping 0xFFFF to 0x0000.
- R5: Mode 2 (pre-decrement) presents pointer−1 on `ptr_addr[15:0]` and writes that value back, wrapping 0x0000 to 0xFFFF.
- R6: Mode 3 presents pointer + `ptr_disp` (6-bit, zero-extended, 16-bit wrap) and mode 0 presents the pointer unchanged. Neither mode, and an idle port (`ptr_en`=0), modifies the pointer.
- R7: `ptr_sel` 0, 1, 2 select the pairs at registers 26/27, 28/29 and 30/31, low byte in the even register. Select value 3 gives `ptr_addr` = 0 and updates nothing.
- R8: `ext_we` loads `ext_wdata` into the extension register on the next edge. When `ptr_sel`=2 and `ptr_xt`=1, `ptr_addr[23:16]` equals the extension register. Otherwise `ptr_addr[23:16]` is 0. The extension is never changed by pointer arithmetic.
- R9: For `mem_addr` below 0x20, `mem_hit`=1 and `mem_rdata` returns the register whose index equals the address, and `mem_we` writes `mem_wdata` into it. For any higher address, `mem_hit`=0, `mem_rdata`=0 and writes are ignored.
- R10: Write priority is register write port over data-space write over pointer write-back. A pointer write-back is dropped entirely when either other source writes any byte of the selected pair in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Byte read port A index |
| rd_a_data | output | 8 | Byte read port A data |
| rd_b_idx | input | 5 | Byte read port B index |
| rd_b_data | output | 8 | Byte read port B data |
| rd_w_idx | input | 5 | 16-bit read port pair index |
| rd_w_data | output | 16 | 16-bit read port data {odd, even} |
| wr_en | input | 1 | Register write enable |
| wr_wide | input | 1 | 1: 16-bit pair write, 0: byte write |
| wr_idx | input | 5 | Register write index |
| wr_data | input | 16 | Register write data |
| ptr_en | input | 1 | Pointer port enable |
| ptr_sel | input | 2 | Pointer select (0, 1, 2; 3 = none) |
| ptr_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| ptr_disp | input | 6 | Unsigned displacement |
| ptr_xt | input | 1 | Use the extension register above pointer 2 |
| ptr_addr | output | 24 | Effective address |
| ext_we | input | 1 | Extension register write enable |
| ext_wdata | input | 8 | Extension register write data |
| mem_addr | input | 16 | Data-space address |
| mem_we | input | 1 | Data-space write enable |
| mem_wdata | input | 8 | Data-space write data |
| mem_rdata | output | 8 | Data-space read data |
| mem_hit | output | 1 | Address falls in the register window |

## Verification
Assertions check the following on every cycle: the all-zero state after reset, the value a pointer holds after a post-increment, a pre-decrement or a displacement access, a data-space write landing in its register, the register write port winning over a pointer update, and the upper address byte staying zero outside extended accesses. Only the bench's scenarios can show the combinational read values on all three read ports, the alignment of odd wide indices, the wrap of a pointer at 0x0000 and 0xFFFF, and the select value that updates nothing. They also show that out-of-window data-space writes leave every register unchanged and that priority holds when all three write sources collide on one pair.

// File: rtl/wreg_pkg.sv
package wreg_pkg;

    localparam int NREG_DEF  = 32;
    localparam int DW_DEF    = 8;
    localparam int DISPW_DEF = 6;
    localparam int XW_DEF    = 8;
    localparam int MAW_DEF   = 16;

    typedef enum logic [1:0] {
        PSEL_P0   = 2'd0,
        PSEL_P1   = 2'd1,
        PSEL_P2   = 2'd2,
        PSEL_NONE = 2'd3
    } psel_e;

    typedef enum logic [1:0] {
        PM_PLAIN   = 2'd0,
        PM_POSTINC = 2'd1,
        PM_PREDEC  = 2'd2,
        PM_DISP    = 2'd3
    } pmode_e;

    function automatic logic mode_writes_back(pmode_e m);
        return (m == PM_POSTINC) || (m == PM_PREDEC);
    endfunction

endpackage

// File: rtl/wreg_storage.sv
module wreg_storage #(
    parameter int NREG = wreg_pkg::NREG_DEF,
    parameter int DW   = wreg_pkg::DW_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREG-1:0] we,
    input  logic [DW-1:0]   wd [NREG],
    output logic [DW-1:0]   q  [NREG]
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= '0;
            else if (we[i])
                q[i] <= wd[i];
        end
    end

    logic after_rst;
    logic any_set;

    always_ff @(posedge clk) after_rst <= rst;

    always_comb begin
        any_set = 1'b0;
        for (int i = 0; i < NREG; i++)
            any_set = any_set | (|q[i]);
    end

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        after_rst |-> !any_set);

endmodule

// File: rtl/wreg_ptr_unit.sv
module wreg_ptr_unit #(
    parameter int PW    = 2 * wreg_pkg::DW_DEF,
    parameter int XW    = wreg_pkg::XW_DEF,
    parameter int DISPW = wreg_pkg::DISPW_DEF
) (
    input  wreg_pkg::pmode_e  mode,
    input  logic [PW-1:0]     cur,
    input  logic [DISPW-1:0]  disp,
    input  logic              use_ext,
    input  logic [XW-1:0]     ext_val,
    output logic [PW+XW-1:0]  ea,
    output logic [PW-1:0]     next_val,
    output logic              wb
);
    import wreg_pkg::*;

    logic [PW-1:0] inc_val;
    logic [PW-1:0] dec_val;
    logic [PW-1:0] low_ea;

    assign inc_val = cur + PW'(1);
    assign dec_val = cur - PW'(1);

    always_comb begin
        unique case (mode)
            PM_POSTINC: begin low_ea = cur;               next_val = inc_val; end
            PM_PREDEC:  begin low_ea = dec_val;           next_val = dec_val; end
            PM_DISP:    begin low_ea = cur + PW'(disp);   next_val = cur;     end
            default:    begin low_ea = cur;               next_val = cur;     end
        endcase
    end

    assign wb = mode_writes_back(mode);
    assign ea = {(use_ext ? ext_val : XW'(0)), low_ea};

endmodule

// File: rtl/wreg_alias.sv
module wreg_alias #(
    parameter int NREG = wreg_pkg::NREG_DEF,
    parameter int MAW  = wreg_pkg::MAW_DEF,
    localparam int AW  = $clog2(NREG)
) (
    input  logic [MAW-1:0] addr,
    output logic           hit,
    output logic [AW-1:0]  idx
);

    assign hit = (addr < MAW'(NREG));
    assign idx = addr[AW-1:0];

endmodule

// File: rtl/wreg_file_top.sv
module wreg_file_top #(
    parameter int NREG  = wreg_pkg::NREG_DEF,
    parameter int DW    = wreg_pkg::DW_DEF,
    parameter int DISPW = wreg_pkg::DISPW_DEF,
    parameter int XW    = wreg_pkg::XW_DEF,
    parameter int MAW   = wreg_pkg::MAW_DEF,
    localparam int AW   = $clog2(NREG),
    localparam int PW   = 2 * DW,
    localparam int EAW  = PW + XW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    rd_a_idx,
    output logic [DW-1:0]    rd_a_data,
    input  logic [AW-1:0]    rd_b_idx,
    output logic [DW-1:0]    rd_b_data,
    input  logic [AW-1:0]    rd_w_idx,
    output logic [PW-1:0]    rd_w_data,
    input  logic             wr_en,
    input  logic             wr_wide,
    input  logic [AW-1:0]    wr_idx,
    input  logic [PW-1:0]    wr_data,
    input  logic             ptr_en,
    input  logic [1:0]       ptr_sel,
    input  logic [1:0]       ptr_mode,
    input  logic [DISPW-1:0] ptr_disp,
    input  logic             ptr_xt,
    output logic [EAW-1:0]   ptr_addr,
    input  logic             ext_we,
    input  logic [XW-1:0]    ext_wdata,
    input  logic [MAW-1:0]   mem_addr,
    input  logic             mem_we,
    input  logic [DW-1:0]    mem_wdata,
    output logic [DW-1:0]    mem_rdata,
    output logic             mem_hit
);
    import wreg_pkg::*;

    localparam int NPTR  = 3;
    localparam int PBASE = NREG - 2 * NPTR;

    logic [DW-1:0]   q  [NREG];
    logic [DW-1:0]   wd [NREG];
    logic [NREG-1:0] we;
    logic [XW-1:0]   ext_q;

    psel_e  sel;
    pmode_e mode;
    assign sel  = psel_e'(ptr_sel);
    assign mode = pmode_e'(ptr_mode);

    // ---------------- read ports ----------------
    logic [AW-1:0] w_lo, w_hi;
    assign w_lo      = {rd_w_idx[AW-1:1], 1'b0};
    assign w_hi      = {rd_w_idx[AW-1:1], 1'b1};
    assign rd_a_data = q[rd_a_idx];
    assign rd_b_data = q[rd_b_idx];
    assign rd_w_data = {q[w_hi], q[w_lo]};

    // ---------------- extension register ----------------
    always_ff @(posedge clk) begin
        if (rst)
            ext_q <= '0;
        else if (ext_we)
            ext_q <= ext_wdata;
    end

    // ---------------- pointer selection ----------------
    logic          sel_ok;
    logic [AW-1:0] p_lo, p_hi;
    logic [PW-1:0] p_cur;
    logic [PW-1:0] ptr_vals [4];

    for (genvar s = 0; s < NPTR; s++) begin : g_pval
        assign ptr_vals[s] = {q[PBASE + 2*s + 1], q[PBASE + 2*s]};
    end
    assign ptr_vals[3] = '0;

    assign sel_ok = (sel != PSEL_NONE);
    assign p_lo   = AW'(PBASE) + AW'({ptr_sel, 1'b0});
    assign p_hi   = p_lo | AW'(1);
    assign p_cur  = sel_ok ? {q[p_hi], q[p_lo]} : '0;

    logic [EAW-1:0] ea;
    logic [PW-1:0]  p_next;
    logic           p_wb;

    wreg_ptr_unit #(.PW(PW), .XW(XW), .DISPW(DISPW)) u_ptr (
        .mode     (mode),
        .cur      (p_cur),
        .disp     (ptr_disp),
        .use_ext  (ptr_xt && (sel == PSEL_P2)),
        .ext_val  (ext_q),
        .ea       (ea),
        .next_val (p_next),
        .wb       (p_wb)
    );

    assign ptr_addr = sel_ok ? ea : '0;

    // ---------------- data-space alias ----------------
    logic          a_hit;
    logic [AW-1:0] a_idx;

    wreg_alias #(.NREG(NREG), .MAW(MAW)) u_alias (
        .addr (mem_addr),
        .hit  (a_hit),
        .idx  (a_idx)
    );

    assign mem_hit   = a_hit;
    assign mem_rdata = a_hit ? q[a_idx] : '0;

    // ---------------- write arbitration ----------------
    logic a_wr, alu_on_pair, alias_on_pair, ptr_wr;
    assign a_wr          = mem_we && a_hit;
    assign alu_on_pair   = wr_en && (wr_idx[AW-1:1] == p_lo[AW-1:1]);
    assign alias_on_pair = a_wr && (a_idx[AW-1:1] == p_lo[AW-1:1]);
    assign ptr_wr        = ptr_en && sel_ok && p_wb && !alu_on_pair && !alias_on_pair;

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            we[i] = 1'b0;
            wd[i] = '0;
            if (ptr_wr && (AW'(i) == p_lo)) begin
                we[i] = 1'b1;
                wd[i] = p_next[DW-1:0];
            end
            if (ptr_wr && (AW'(i) == p_hi)) begin
                we[i] = 1'b1;
                wd[i] = p_next[PW-1:DW];
            end
            if (a_wr && (AW'(i) == a_idx)) begin
                we[i] = 1'b1;
                wd[i] = mem_wdata;
            end
            if (wr_en && !wr_wide && (AW'(i) == wr_idx)) begin
                we[i] = 1'b1;
                wd[i] = wr_data[DW-1:0];
            end
            if (wr_en && wr_wide && (AW'(i) == {wr_idx[AW-1:1], 1'b0})) begin
                we[i] = 1'b1;
                wd[i] = wr_data[DW-1:0];
            end
            if (wr_en && wr_wide && (AW'(i) == {wr_idx[AW-1:1], 1'b1})) begin
                we[i] = 1'b1;
                wd[i] = wr_data[PW-1:DW];
            end
        end
    end

    wreg_storage #(.NREG(NREG), .DW(DW)) u_store (
        .clk (clk),
        .rst (rst),
        .we  (we),
        .wd  (wd),
        .q   (q)
    );

    // ---------------- assertions ----------------
    logic quiet_pair;
    logic alu_hits_alias;
    assign quiet_pair     = !alu_on_pair && !alias_on_pair;
    assign alu_hits_alias = wr_en && (wr_wide ? (wr_idx[AW-1:1] == a_idx[AW-1:1])
                                              : (wr_idx == a_idx));

    assert_postinc_value_R4: assert property (@(posedge clk) disable iff (rst)
        (ptr_en && sel_ok && mode == PM_POSTINC && quiet_pair)
        |=> ptr_vals[$past(ptr_sel)] == $past(ptr_addr[PW-1:0]) + PW'(1));

    assert_predec_value_R5: assert property (@(posedge clk) disable iff (rst)
        (ptr_en && sel_ok && mode == PM_PREDEC && quiet_pair)
        |=> ptr_vals[$past(ptr_sel)] == $past(ptr_addr[PW-1:0]));

    assert_disp_keeps_ptr_R6: assert property (@(posedge clk) disable iff (rst)
        (ptr_en && sel_ok && mode == PM_DISP && quiet_pair)
        |=> ptr_vals[$past(ptr_sel)] == $past(p_cur));

    assert_ext_only_extended_R8: assert property (@(posedge clk) disable iff (rst)
        !(ptr_xt && sel == PSEL_P2) |-> ptr_addr[EAW-1:PW] == '0);

    assert_alias_write_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_we && a_hit && !alu_hits_alias) |=> q[$past(a_idx)] == $past(mem_wdata));

    assert_alu_beats_ptr_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_wide && ptr_en && sel_ok && p_wb && alu_on_pair)
        |=> ptr_vals[$past(ptr_sel)] == $past(wr_data));

endmodule

// File: tb/wreg_file_top_tb.sv
module wreg_file_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  rd_a_idx, rd_b_idx, rd_w_idx, wr_idx;
    logic [7:0]  rd_a_data, rd_b_data;
    logic [15:0] rd_w_data, wr_data;
    logic        wr_en, wr_wide;
    logic        ptr_en, ptr_xt;
    logic [1:0]  ptr_sel, ptr_mode;
    logic [5:0]  ptr_disp;
    logic [23:0] ptr_addr;
    logic        ext_we;
    logic [7:0]  ext_wdata;
    logic [15:0] mem_addr;
    logic        mem_we, mem_hit;
    logic [7:0]  mem_wdata, mem_rdata;

    always #4 clk = ~clk;

    wreg_file_top u_dut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .rd_w_idx(rd_w_idx), .rd_w_data(rd_w_data),
        .wr_en(wr_en), .wr_wide(wr_wide), .wr_idx(wr_idx), .wr_data(wr_data),
        .ptr_en(ptr_en), .ptr_sel(ptr_sel), .ptr_mode(ptr_mode),
        .ptr_disp(ptr_disp), .ptr_xt(ptr_xt), .ptr_addr(ptr_addr),
        .ext_we(ext_we), .ext_wdata(ext_wdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_hit(mem_hit)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    logic [7:0] m [32];
    logic [7:0] m_ext;
    string tag_a = "R2";
    string tag_w = "R3";

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ptr_of(logic [1:0] s);
        int b = 26 + 2 * int'(s);
        return {m[b+1], m[b]};
    endfunction

    function automatic logic [23:0] exp_ea();
        logic [15:0] p;
        logic [15:0] lo;
        if (ptr_sel == 2'd3) return 24'h0;
        p = ptr_of(ptr_sel);
        case (ptr_mode)
            2'd1:    lo = p;
            2'd2:    lo = p - 16'd1;
            2'd3:    lo = p + {10'd0, ptr_disp};
            default: lo = p;
        endcase
        return {((ptr_sel == 2'd2) && ptr_xt) ? m_ext : 8'h00, lo};
    endfunction

    function automatic string ea_tag();
        if (ptr_sel == 2'd3) return "R7";
        if (ptr_sel == 2'd2 && ptr_xt) return "R8";
        case (ptr_mode)
            2'd1:    return "R4";
            2'd2:    return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic idle_inputs();
        wr_en = 0; wr_wide = 0; wr_idx = 0; wr_data = 0;
        ptr_en = 0; ptr_sel = 0; ptr_mode = 0; ptr_disp = 0; ptr_xt = 0;
        ext_we = 0; ext_wdata = 0; mem_addr = 16'hFFFF; mem_we = 0; mem_wdata = 0;
    endtask

    // inputs are set by the caller right after a falling edge
    task automatic check_and_advance();
        logic [7:0] nm [32];
        logic [7:0] nx;
        int          b;
        logic [15:0] p, np;
        bit          hit, touch;
        #1;
        cmp(tag_a, "rd_a", 32'(rd_a_data), 32'(m[rd_a_idx]));
        cmp("R2", "rd_b", 32'(rd_b_data), 32'(m[rd_b_idx]));
        cmp(tag_w, "rd_w", 32'(rd_w_data),
            32'({m[{rd_w_idx[4:1], 1'b1}], m[{rd_w_idx[4:1], 1'b0}]}));
        cmp(ea_tag(), "ptr_addr", 32'(ptr_addr), 32'(exp_ea()));
        hit = (mem_addr < 16'd32);
        cmp("R9", "mem_hit", 32'(mem_hit), 32'(hit));
        cmp("R9", "mem_rdata", 32'(mem_rdata), hit ? 32'(m[mem_addr[4:0]]) : 32'h0);
        // next state
        foreach (m[i]) nm[i] = m[i];
        nx = ext_we ? ext_wdata : m_ext;
        if (ptr_en && ptr_sel != 2'd3 && (ptr_mode == 2'd1 || ptr_mode == 2'd2)) begin
            b = 26 + 2 * int'(ptr_sel);
            touch = (wr_en && (int'(wr_idx) >> 1) == (b >> 1)) ||
                    (mem_we && hit && (int'(mem_addr[4:0]) >> 1) == (b >> 1));
            if (!touch) begin
                p  = ptr_of(ptr_sel);
                np = (ptr_mode == 2'd1) ? p + 16'd1 : p - 16'd1;
                nm[b] = np[7:0];
                nm[b+1] = np[15:8];
            end
        end
        if (mem_we && hit) nm[mem_addr[4:0]] = mem_wdata;
        if (wr_en) begin
            if (wr_wide) begin
                nm[{wr_idx[4:1], 1'b0}] = wr_data[7:0];
                nm[{wr_idx[4:1], 1'b1}] = wr_data[15:8];
            end else begin
                nm[wr_idx] = wr_data[7:0];
            end
        end
        @(posedge clk);
        foreach (m[i]) m[i] = nm[i];
        m_ext = nx;
        @(negedge clk);
        tag_a = "R2";
        tag_w = "R3";
    endtask

    task automatic wide_write(int idx, logic [15:0] v);
        idle_inputs();
        wr_en = 1; wr_wide = 1; wr_idx = 5'(idx); wr_data = v;
        check_and_advance();
    endtask

    task automatic ptr_op(logic [1:0] s, logic [1:0] md, logic [5:0] d, logic xt);
        idle_inputs();
        ptr_en = 1; ptr_sel = s; ptr_mode = md; ptr_disp = d; ptr_xt = xt;
        rd_w_idx = 5'(26 + 2 * int'(s));
        check_and_advance();
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240517);
        idle_inputs();
        rd_a_idx = 0; rd_b_idx = 0; rd_w_idx = 0;
        rst = 1;
        foreach (m[i]) m[i] = 8'h00;
        m_ext = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state of every register, via all three read ports
        for (int i = 0; i < 32; i++) begin
            idle_inputs();
            rd_a_idx = 5'(i); rd_b_idx = 5'(31 - i); rd_w_idx = 5'(i);
            tag_a = "R1"; tag_w = "R1";
            check_and_advance();
        end
        idle_inputs(); ptr_sel = 2'd2; ptr_xt = 1;   // R1: extension cleared
        check_and_advance();

        // R2: byte write, same-cycle read sees old value
        idle_inputs();
        wr_en = 1; wr_idx = 5'd5; wr_data = 16'h77A5; rd_a_idx = 5'd5;
        check_and_advance();
        idle_inputs(); rd_a_idx = 5'd5; check_and_advance();

        // R3: odd index wide write aligns down
        wide_write(13, 16'hBEEF);
        idle_inputs(); rd_w_idx = 5'd13; rd_a_idx = 5'd12; rd_b_idx = 5'd13;
        check_and_advance();

        // R4: post-increment wrap on pointer 0
        wide_write(26, 16'hFFFF);
        ptr_op(2'd0, 2'd1, 6'd0, 0);
        ptr_op(2'd0, 2'd1, 6'd0, 0);
        // R5: pre-decrement wrap on pointer 1
        wide_write(28, 16'h0000);
        ptr_op(2'd1, 2'd2, 6'd0, 0);
        ptr_op(2'd1, 2'd2, 6'd0, 0);
        // R6: displacement with 16-bit wrap, plain, pointer unchanged
        wide_write(30, 16'hFFF0);
        ptr_op(2'd2, 2'd3, 6'd63, 0);
        ptr_op(2'd2, 2'd0, 6'd9, 0);
        // R7: select 3 updates nothing
        ptr_op(2'd3, 2'd1, 6'd0, 0);
        ptr_op(2'd3, 2'd2, 6'd0, 0);
        // R8: extension prefixes pointer 2 only
        idle_inputs(); ext_we = 1; ext_wdata = 8'hA7; check_and_advance();
        ptr_op(2'd2, 2'd1, 6'd0, 1);
        ptr_op(2'd0, 2'd0, 6'd0, 1);
        ptr_op(2'd2, 2'd2, 6'd0, 0);
        // R9: out-of-window write ignored, in-window write lands
        idle_inputs(); mem_addr = 16'h0020; mem_we = 1; mem_wdata = 8'h5C;
        check_and_advance();
        for (int i = 0; i < 32; i++) begin
            idle_inputs(); mem_addr = 16'(i); tag_a = "R9"; rd_a_idx = 5'(i);
            check_and_advance();
        end
        idle_inputs(); mem_addr = 16'h001B; mem_we = 1; mem_wdata = 8'hC3;
        check_and_advance();
        // R10: collisions on pointer pairs
        idle_inputs();
        wr_en = 1; wr_idx = 5'd27; wr_data = 16'h0011;
        ptr_en = 1; ptr_sel = 2'd0; ptr_mode = 2'd1; mem_addr = 16'h001A; mem_we = 1;
        mem_wdata = 8'h99;
        check_and_advance();
        idle_inputs(); rd_w_idx = 5'd26; tag_w = "R10"; check_and_advance();
        idle_inputs();
        ptr_en = 1; ptr_sel = 2'd1; ptr_mode = 2'd2; mem_addr = 16'h001D; mem_we = 1;
        mem_wdata = 8'h42;
        check_and_advance();
        idle_inputs(); rd_w_idx = 5'd28; tag_w = "R10"; check_and_advance();

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            idle_inputs();
            rd_a_idx = 5'($urandom);
            rd_b_idx = 5'(($urandom % 2) ? 24 + $urandom % 8 : $urandom);
            rd_w_idx = 5'(24 + $urandom % 8);
            wr_en    = ($urandom % 3) == 0;
            wr_wide  = $urandom % 2;
            wr_idx   = 5'(($urandom % 2) ? 24 + $urandom % 8 : $urandom);
            wr_data  = 16'($urandom);
            ptr_en   = ($urandom % 4) != 0;
            ptr_sel  = 2'($urandom);
            ptr_mode = 2'($urandom);
            ptr_disp = 6'($urandom);
            ptr_xt   = $urandom % 2;
            ext_we   = ($urandom % 8) == 0;
            ext_wdata = 8'($urandom);
            mem_addr = ($urandom % 2) ? 16'($urandom % 32) : 16'($urandom);
            mem_we   = ($urandom % 3) == 0;
            mem_wdata = 8'($urandom);
            check_and_advance();
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule